// File: doc/BRIEF.md
# Keyed Random-Bit Parity Encryptor

This block turns one message bit into one cipher bit every clock cycle. A pool of 32 random bits is shared by all 64 selectors in a cycle. A secret key holds 64 independent 5-bit fields. Each field picks one pool bit. The 64 picked bits are folded into a single parity bit, and that parity is XORed with the message bit.

A receiver that holds the same key and sees the same pool sample runs the same operation on the cipher bit and gets the message back. The key is shifted in serially, one bit per cycle. Requests are refused until a complete key has been loaded.

The pool comes from one of two places. It is either an internal 32-bit maximal-length LFSR that starts from a nonzero seed, or an external input port that stands in for physical noise sources.

Top module: `keyed_parity_cipher`

## Requirements
- R1: While `key_load` is high, the block takes one `key_bit` per cycle. The 320 key bits arrive field 63 first and field 0 last. Within each field the most significant bit (bit 4) comes first. The value of field j selects pool bit `pool[field_j]`.
- R2: `key_ready` rises in the cycle after the 320th consecutive `key_load` cycle. It drops after the first cycle of a new load. Lowering `key_load` before 320 bits throws the partial load away and leaves `key_ready` low. `key_ready` changes only while a load is in progress.
- R3: A request (`in_valid` high) is accepted only when `key_ready` is high and `key_load` is low. A request that is not accepted produces no `out_valid` and does not advance the LFSR.
- R4: Each accepted request gives `out_valid` high exactly one cycle later. Requests can be accepted on back-to-back cycles, one per cycle.
- R5: `out_bit` = `in_bit` XOR (XOR over j=0..63 of `pool[field_j]`). The pool value used is the one present in the cycle the request is accepted.
- R6: Decode (`in_decode`=1) applies the same parity XOR to a cipher bit, which recovers the message bit. `out_decode` echoes the mode of the accepted request.
- R7: With `pool_ext_en`=1 the pool is `pool_in`. With `pool_ext_en`=0 the pool is the LFSR state.
- R8: The LFSR resets to the seed 32'h1D872B41. It steps once for each request accepted with `pool_ext_en`=0. Each step is next = {s[30:0], s[31]^s[21]^s[1]^s[0]}. In every other cycle the LFSR holds its value.
- R9: While reset is held and in the cycle after it, `key_ready`, `out_valid`, `out_bit` and `out_decode` are 0.
- R10: In any cycle where `out_valid` is low, `out_bit` and `out_decode` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| key_load | input | 1 | Key shift enable |
| key_bit | input | 1 | Serial key bit |
| key_ready | output | 1 | A full key is held |
| pool_ext_en | input | 1 | 1: pool from `pool_in`, 0: pool from the LFSR |
| pool_in | input | 32 | External random pool |
| in_valid | input | 1 | Request strobe |
| in_bit | input | 1 | Message bit, or cipher bit when decoding |
| in_decode | input | 1 | Request is a decode |
| out_valid | output | 1 | Result strobe |
| out_bit | output | 1 | Cipher bit, or recovered message bit |
| out_decode | output | 1 | Mode of the result |

## Verification
A single wrong key field, or a bit that arrived in the wrong order within a field, changes the selected pool bit. That error appears on `out_bit` in the cycle after the first request whose pool differs at the two bit positions involved, so each pool vector is chosen to separate particular positions. A wrong bit count during loading shows up at once as a misplaced edge on `key_ready`. An LFSR that steps when it should not, or steps with the wrong taps, makes the next internal-pool result disagree with a model that steps only on accepted requests.

// File: rtl/keyed_parity_cipher.sv
module keyed_parity_cipher #(
  parameter int POOL_W = 32,
  parameter int SEL_N = 64,
  parameter logic [POOL_W-1:0] LFSR_SEED = 32'h1D87_2B41,
  parameter logic [POOL_W-1:0] LFSR_TAPS = 32'h8020_0003
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_load,
  input  logic              key_bit,
  output logic              key_ready,
  input  logic              pool_ext_en,
  input  logic [POOL_W-1:0] pool_in,
  input  logic              in_valid,
  input  logic              in_bit,
  input  logic              in_decode,
  output logic              out_valid,
  output logic              out_bit,
  output logic              out_decode
);
  localparam int SEL_W = $clog2(POOL_W);
  localparam int KEY_BITS = SEL_N * SEL_W;
  localparam int CNT_W = $clog2(KEY_BITS + 1);

  logic [KEY_BITS-1:0] key_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [POOL_W-1:0]   lfsr_q;
  logic [POOL_W-1:0]   pool;
  logic [SEL_N-1:0]    picked;
  logic                accept;

  assign pool   = pool_ext_en ? pool_in : lfsr_q;
  assign accept = in_valid && key_ready && !key_load;

  for (genvar j = 0; j < SEL_N; j++) begin : g_sel
    assign picked[j] = pool[key_q[j*SEL_W +: SEL_W]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q     <= '0;
      cnt_q     <= '0;
      key_ready <= 1'b0;
    end else if (key_load) begin
      key_q <= {key_q[KEY_BITS-2:0], key_bit};
      if (cnt_q == CNT_W'(KEY_BITS - 1)) begin
        cnt_q     <= '0;
        key_ready <= 1'b1;
      end else begin
        cnt_q     <= cnt_q + 1'b1;
        key_ready <= 1'b0;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr_q     <= LFSR_SEED;
      out_valid  <= 1'b0;
      out_bit    <= 1'b0;
      out_decode <= 1'b0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_bit    <= in_bit ^ (^picked);
        out_decode <= in_decode;
        if (!pool_ext_en)
          lfsr_q <= {lfsr_q[POOL_W-2:0], ^(lfsr_q & LFSR_TAPS)};
      end
    end
  end
endmodule

// File: rtl/keyed_parity_cipher_chk.sv
module keyed_parity_cipher_chk (
  input logic clk,
  input logic rst,
  input logic key_load,
  input logic key_ready,
  input logic in_valid,
  input logic out_valid,
  input logic out_bit,
  input logic out_decode
);
  assert_accept_latency_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid && key_ready && !key_load));

  assert_refused_R3: assert property (@(posedge clk) disable iff (rst)
    $past(key_load) |-> !out_valid);

  assert_hold_outputs_R10: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_bit) && $stable(out_decode)));

  assert_ready_drops_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(key_load) |=> !key_ready);

  assert_ready_from_load_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(key_ready) |-> $past(key_load));

  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(key_load) |-> key_ready == $past(key_ready));

  assert_reset_state_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!key_ready && !out_valid && !out_bit && !out_decode));
endmodule

bind keyed_parity_cipher keyed_parity_cipher_chk u_chk (
  .clk(clk), .rst(rst), .key_load(key_load), .key_ready(key_ready),
  .in_valid(in_valid), .out_valid(out_valid), .out_bit(out_bit),
  .out_decode(out_decode)
);

// File: tb/test_keyed_parity_cipher.sv
module test_keyed_parity_cipher;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic key_load = 1'b0, key_bit = 1'b0, key_ready;
  logic pool_ext_en = 1'b1;
  logic [31:0] pool_in = '0;
  logic in_valid = 1'b0, in_bit = 1'b0, in_decode = 1'b0;
  logic out_valid, out_bit, out_decode;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;
  logic [4:0] key_m [64];
  logic [31:0] lfsr_m;

  always #10 clk = ~clk;

  keyed_parity_cipher i_keyed_parity_cipher (
    .clk(clk), .rst(rst), .key_load(key_load), .key_bit(key_bit),
    .key_ready(key_ready), .pool_ext_en(pool_ext_en), .pool_in(pool_in),
    .in_valid(in_valid), .in_bit(in_bit), .in_decode(in_decode),
    .out_valid(out_valid), .out_bit(out_bit), .out_decode(out_decode)
  );

  // pool, in_bit, decode, expected out_bit (key A: field j = j for j<32, else 0)
  localparam logic [34:0] VEC [8] = '{
    {32'h0000_0000, 1'b0, 1'b0, 1'b0},
    {32'h0000_0001, 1'b0, 1'b0, 1'b1},
    {32'h8000_0000, 1'b1, 1'b0, 1'b0},
    {32'hFFFF_FFFF, 1'b1, 1'b0, 1'b1},
    {32'h0000_0003, 1'b0, 1'b0, 1'b0},
    {32'h1234_5678, 1'b0, 1'b1, 1'b1},
    {32'hF000_000F, 1'b1, 1'b1, 1'b1},
    {32'h0000_0700, 1'b1, 1'b0, 1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic model_par(input logic [31:0] p);
    logic r = 1'b0;
    for (int j = 0; j < 64; j++) r ^= p[key_m[j]];
    return r;
  endfunction

  function automatic logic [31:0] lfsr_step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic load_key(input int kind, input bit check_ready);
    for (int j = 0; j < 64; j++)
      if (kind == 0) key_m[j] = (j < 32) ? 5'(j) : 5'd0;
      else key_m[j] = (j == 63) ? 5'd31 : (j == 62) ? 5'd3 : 5'd7;
    key_load = 1'b1;
    for (int f = 63; f >= 0; f--)
      for (int b = 4; b >= 0; b--) begin
        key_bit = key_m[f][b];
        @(negedge clk);
        if (check_ready && f == 0 && b == 1)
          check(key_ready == 1'b0, "R2 ready early", 32'(key_ready), 0);
      end
    key_load = 1'b0;
    if (check_ready) check(key_ready == 1'b1, "R2 ready after 320", 32'(key_ready), 1);
  endtask

  task automatic request(input logic m, input logic dec);
    in_valid = 1'b1; in_bit = m; in_decode = dec;
    @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic c_saved;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!key_ready && !out_valid && !out_bit && !out_decode, "R9 reset state",
          {key_ready, out_valid, out_bit, out_decode}, 0);

    request(1'b1, 1'b0); in_valid = 1'b0;
    check(!out_valid, "R3 no key", 32'(out_valid), 0);

    load_key(0, 1'b1);
    pool_ext_en = 1'b1;
    for (int i = 0; i < 8; i++) begin
      pool_in = VEC[i][34:3];
      request(VEC[i][2], VEC[i][1]);
      check(out_valid && out_bit == VEC[i][0] && out_decode == VEC[i][1],
            $sformatf("R4 R5 R7 vector %0d", i),
            {out_valid, out_bit, out_decode}, {1'b1, VEC[i][0], VEC[i][1]});
    end
    in_valid = 1'b0;

    pool_in = 32'h0F0F_0101;
    request(1'b1, 1'b0); in_valid = 1'b0;
    c_saved = out_bit;
    request(c_saved, 1'b1); in_valid = 1'b0;
    check(out_bit == 1'b1 && out_decode, "R6 round trip", {out_bit, out_decode}, 3);

    @(negedge clk);
    check(!out_valid && out_bit == 1'b1 && out_decode, "R10 hold", {out_valid, out_bit, out_decode}, 3);

    pool_ext_en = 1'b0;
    lfsr_m = 32'h1D87_2B41;
    for (int i = 0; i < 4; i++) begin
      request(1'(i), 1'b0);
      check(out_valid && out_bit == (1'(i) ^ model_par(lfsr_m)), "R8 lfsr pool",
            32'(out_bit), 32'(1'(i) ^ model_par(lfsr_m)));
      lfsr_m = lfsr_step(lfsr_m);
    end
    in_valid = 1'b0;

    key_load = 1'b1; in_valid = 1'b1; in_bit = 1'b1;
    for (int i = 0; i < 100; i++) begin
      key_bit = 1'(i);
      @(negedge clk);
      if (i > 0) check(!out_valid, "R3 during load", 32'(out_valid), 0);
    end
    key_load = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check(!key_ready, "R2 partial load", 32'(key_ready), 0);
    request(1'b1, 1'b0); in_valid = 1'b0;
    check(!out_valid, "R3 partial key", 32'(out_valid), 0);

    load_key(1, 1'b1);
    request(1'b0, 1'b0); in_valid = 1'b0;
    check(out_valid && out_bit == model_par(lfsr_m), "R8 lfsr held while refused",
          32'(out_bit), 32'(model_par(lfsr_m)));

    pool_ext_en = 1'b1;
    pool_in = 32'h0000_0008;
    request(1'b0, 1'b0);
    check(out_bit == 1'b1, "R1 field bit order (bit 3)", 32'(out_bit), 1);
    pool_in = 32'h0100_0000;
    request(1'b0, 1'b0);
    check(out_bit == 1'b0, "R1 reversed field not used (bit 24)", 32'(out_bit), 0);
    pool_in = 32'h8000_0008;
    request(1'b1, 1'b0);
    check(out_bit == 1'b1, "R1 R5 two picks cancel", 32'(out_bit), 1);
    pool_in = 32'h0000_0080;
    request(1'b0, 1'b1); in_valid = 1'b0;
    check(out_bit == 1'b0 && out_decode, "R5 R6 repeated field cancels", {out_bit, out_decode}, 1);

    @(negedge clk);
    finish_run();
  end
endmodule